// File: doc/BRIEF.md
# Sparse Vector Compaction and Expansion Unit

This block converts vectors between a dense layout and a packed sparse layout. It also merges vectors under a control mask. The vectors live in a small local register file inside the block. The register file has `NREG` vectors, and each vector holds `MAXLEN` elements of `DW` bits. A host loads operands and reads results through an element-wide port while the block is idle.

An operation starts with a one-cycle `start` pulse. The pulse carries an operation code, three register selectors (source, auxiliary, destination) and an active length. The block then handles one element per clock and signals completion with a one-cycle `done` pulse. The three operations are:

- **Compaction (gather).** Scans the source vector and writes each non-zero element to the destination. It writes the position of that element to the auxiliary register, in the same slot.
- **Expansion (scatter).** Clears the destination, then places each value at the position named by the matching auxiliary element.
- **Merge (mask).** Copies source elements into the destination only where the auxiliary (control) element is non-zero.

The source, auxiliary and destination selectors of one operation must name three different registers.

Top module: `sgs_unit`

## Requirements
- R1: With `op` = 0 (gather), the non-zero elements among source positions 0 to L-1 are written to destination slots 0, 1, 2, ... in ascending position order. `out_len` then shows how many elements were kept.
- R2: In a gather, auxiliary slot k receives the source position of the k-th kept element, zero-extended to `DW` bits. Destination and auxiliary slots at or above the kept count are left unchanged.
- R3: With `op` = 1 (scatter), all `MAXLEN` destination positions are first cleared. Then, for k = 0 to L-1, destination position aux[k] receives src[k]. When two pairs name the same position, the pair with the higher k wins.
- R4: A scatter index at or above L is not written. It sets `idx_err`, and `idx_err` stays high until reset.
- R5: With `op` = 2 (mask), destination position e, for e below L, takes src[e] wherever aux[e] is non-zero. Every other destination position keeps its previous value.
- R6: `done` is high for one cycle. Count the cycle in which `start` is sampled as cycle 0. `done` then rises in cycle L+1 for gather and mask, and in cycle L+2 for scatter. `busy` is high between acceptance and `done`, and low while `done` is high.
- R7: A `start` that arrives while `busy` is high is ignored. A `start` with `op` = 3 (reserved) is also ignored: it raises neither `busy` nor `done` and changes no register.
- R8: The active length L is `vec_len`, except that a `vec_len` above `MAXLEN` is treated as `MAXLEN`.
- R9: A host write stores `host_wdata` at element `host_elem` of register `host_sel` only while `busy` is low. A host write while busy is ignored. `host_rdata` shows the selected element combinationally.
- R10: After reset, `busy`, `done`, `idx_err` and `out_len` are zero, and every register element reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request, sampled while idle |
| op | input | 2 | 0 gather, 1 scatter, 2 mask, 3 reserved |
| src_sel | input | SW | Source register |
| aux_sel | input | SW | Index register (gather, scatter) or control register (mask) |
| dst_sel | input | SW | Destination register |
| vec_len | input | LW | Requested active length |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_len | output | LW | Kept count of the last gather |
| idx_err | output | 1 | Sticky out-of-range scatter index flag |
| host_we | input | 1 | Host element write enable |
| host_sel | input | SW | Host register select |
| host_elem | input | IW | Host element select |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Selected element, combinational |

## Verification
The bench runs gather and mask over every pattern of zero and non-zero elements (or of mask bits) on an eight-element configuration. This catches a compaction that leaves gaps, one that writes the wrong index, and a mask that is inverted or clobbers unselected slots. Scatter runs with repeating indices and with every length from zero to full. This exposes a design that lets the earlier pair win, that skips the clear stage, or that lets the first element go missing at length zero. Dedicated cases target:

- an out-of-range index that wrongly lands in memory;
- an error flag that clears itself;
- a start or host write that sneaks in while busy;
- a reserved opcode that triggers an operation;
- an over-long length that is truncated in its low bits instead of clamped.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

  typedef enum logic [1:0] {
    OP_GATHER  = 2'd0,
    OP_SCATTER = 2'd1,
    OP_MASK    = 2'd2,
    OP_RSVD    = 2'd3
  } sgs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2
  } sgs_state_e;

  function automatic logic op_is_valid(input logic [1:0] code);
    return code != OP_RSVD;
  endfunction

endpackage

// File: rtl/sgs_vrf.sv
module sgs_vrf #(
  parameter int NREG   = 4,
  parameter int MAXLEN = 64,
  parameter int DW     = 16,
  parameter int SW     = 2,
  parameter int IW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [SW-1:0] clr_sel,
  input  logic          wa_en,
  input  logic [SW-1:0] wa_sel,
  input  logic [IW-1:0] wa_elem,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [SW-1:0] wb_sel,
  input  logic [IW-1:0] wb_elem,
  input  logic [DW-1:0] wb_data,
  input  logic          hw_en,
  input  logic [SW-1:0] hw_sel,
  input  logic [IW-1:0] hw_elem,
  input  logic [DW-1:0] hw_data,
  input  logic [SW-1:0] ra_sel,
  input  logic [IW-1:0] ra_elem,
  output logic [DW-1:0] ra_data,
  input  logic [SW-1:0] rb_sel,
  input  logic [IW-1:0] rb_elem,
  output logic [DW-1:0] rb_data,
  input  logic [SW-1:0] rh_sel,
  input  logic [IW-1:0] rh_elem,
  output logic [DW-1:0] rh_data
);

  logic [MAXLEN-1:0][DW-1:0] rows [NREG];

  // One row of storage per register; later writes in a cycle take precedence.
  for (genvar r = 0; r < NREG; r++) begin : g_row
    logic [MAXLEN-1:0][DW-1:0] cells;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells <= '0;
      end else begin
        if (clr_en && clr_sel == SW'(r)) cells <= '0;
        if (wa_en && wa_sel == SW'(r)) cells[wa_elem] <= wa_data;
        if (wb_en && wb_sel == SW'(r)) cells[wb_elem] <= wb_data;
        if (hw_en && hw_sel == SW'(r)) cells[hw_elem] <= hw_data;
      end
    end

    assign rows[r] = cells;
  end

  assign ra_data = rows[ra_sel][ra_elem];
  assign rb_data = rows[rb_sel][rb_elem];
  assign rh_data = rows[rh_sel][rh_elem];

endmodule

// File: rtl/sgs_ctrl.sv
module sgs_ctrl
  import sgs_pkg::*;
#(
  parameter int MAXLEN = 64,
  parameter int DW     = 16,
  parameter int SW     = 2,
  parameter int IW     = 6,
  parameter int LW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [SW-1:0] src_sel,
  input  logic [SW-1:0] aux_sel,
  input  logic [SW-1:0] dst_sel,
  input  logic [LW-1:0] vec_len,
  input  logic [DW-1:0] src_data,
  input  logic [DW-1:0] aux_data,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] out_len,
  output logic          idx_err,
  output logic [SW-1:0] rd_src_sel,
  output logic [SW-1:0] rd_aux_sel,
  output logic [IW-1:0] rd_elem,
  output logic          clr_en,
  output logic [SW-1:0] clr_sel,
  output logic          wa_en,
  output logic [SW-1:0] wa_sel,
  output logic [IW-1:0] wa_elem,
  output logic [DW-1:0] wa_data,
  output logic          wb_en,
  output logic [SW-1:0] wb_sel,
  output logic [IW-1:0] wb_elem,
  output logic [DW-1:0] wb_data,
  output logic          ev_accept,
  output logic          ev_keep,
  output logic          ev_discard,
  output logic          ev_last
);

  localparam int CW = (DW > LW) ? DW : LW;

  // Saturate a requested length at the register depth.
  function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] req);
    if (req > LW'(MAXLEN)) return LW'(MAXLEN);
    return req;
  endfunction

  function automatic logic is_live(input logic [DW-1:0] v);
    return |v;
  endfunction

  function automatic logic idx_in_range(input logic [DW-1:0] idx, input logic [LW-1:0] len);
    return CW'(idx) < CW'(len);
  endfunction

  function automatic logic [LW-1:0] bump(input logic [LW-1:0] v, input logic inc);
    return v + LW'(inc);
  endfunction

  sgs_state_e    state_q;
  sgs_op_e       op_q;
  logic [SW-1:0] src_q, aux_q, dst_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] elem_q;
  logic [LW-1:0] keep_q;
  logic [LW-1:0] req_len;

  logic run, in_gather, in_scatter, in_mask;
  logic sc_ok, mask_hit;

  assign req_len    = clamp_len(vec_len);
  assign run        = state_q == ST_RUN;
  assign in_gather  = run && op_q == OP_GATHER;
  assign in_scatter = run && op_q == OP_SCATTER;
  assign in_mask    = run && op_q == OP_MASK;

  assign ev_accept  = state_q == ST_IDLE && start && op_is_valid(op);
  assign ev_keep    = in_gather && is_live(src_data);
  assign sc_ok      = idx_in_range(aux_data, len_q);
  assign ev_discard = in_scatter && !sc_ok;
  assign mask_hit   = in_mask && is_live(aux_data);
  assign ev_last    = run && (elem_q == len_q - LW'(1));

  assign busy       = state_q != ST_IDLE;
  assign rd_src_sel = src_q;
  assign rd_aux_sel = aux_q;
  assign rd_elem    = elem_q[IW-1:0];

  assign clr_en     = state_q == ST_CLEAR;
  assign clr_sel    = dst_q;

  always_comb begin
    wa_en   = ev_keep || (in_scatter && sc_ok) || mask_hit;
    wa_sel  = dst_q;
    wa_data = src_data;
    if (in_gather)       wa_elem = keep_q[IW-1:0];
    else if (in_scatter) wa_elem = aux_data[IW-1:0];
    else                 wa_elem = elem_q[IW-1:0];
  end

  assign wb_en   = ev_keep;
  assign wb_sel  = aux_q;
  assign wb_elem = keep_q[IW-1:0];
  assign wb_data = DW'(elem_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_GATHER;
      src_q   <= '0;
      aux_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      elem_q  <= '0;
      keep_q  <= '0;
      out_len <= '0;
      idx_err <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ev_discard) idx_err <= 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (ev_accept) begin
            op_q   <= sgs_op_e'(op);
            src_q  <= src_sel;
            aux_q  <= aux_sel;
            dst_q  <= dst_sel;
            len_q  <= req_len;
            elem_q <= '0;
            keep_q <= '0;
            if (sgs_op_e'(op) == OP_SCATTER) begin
              state_q <= ST_CLEAR;
            end else if (req_len == '0) begin
              done <= 1'b1;
              if (sgs_op_e'(op) == OP_GATHER) out_len <= '0;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_CLEAR: begin
          if (len_q == '0) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          elem_q <= bump(elem_q, 1'b1);
          keep_q <= bump(keep_q, ev_keep);
          if (ev_last) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            if (op_q == OP_GATHER) out_len <= bump(keep_q, ev_keep);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgs_unit.sv
module sgs_unit #(
  parameter  int NREG   = 4,
  parameter  int MAXLEN = 64,
  parameter  int DW     = 16,
  localparam int SW     = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1,
  localparam int LW     = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [SW-1:0] src_sel,
  input  logic [SW-1:0] aux_sel,
  input  logic [SW-1:0] dst_sel,
  input  logic [LW-1:0] vec_len,
  output logic          busy,
  output logic          done,
  output logic [LW-1:0] out_len,
  output logic          idx_err,
  input  logic          host_we,
  input  logic [SW-1:0] host_sel,
  input  logic [IW-1:0] host_elem,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata
);

  // Named internal events, observed by the bound checker.
  logic          ev_accept, ev_keep, ev_discard, ev_last;
  logic          host_wr_fire;

  logic [SW-1:0] rd_src_sel, rd_aux_sel;
  logic [IW-1:0] rd_elem;
  logic [DW-1:0] src_data, aux_data;
  logic          clr_en;
  logic [SW-1:0] clr_sel;
  logic          wa_en, wb_en;
  logic [SW-1:0] wa_sel, wb_sel;
  logic [IW-1:0] wa_elem, wb_elem;
  logic [DW-1:0] wa_data, wb_data;

  assign host_wr_fire = host_we && !busy;

  sgs_ctrl #(
    .MAXLEN(MAXLEN), .DW(DW), .SW(SW), .IW(IW), .LW(LW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .src_sel   (src_sel),
    .aux_sel   (aux_sel),
    .dst_sel   (dst_sel),
    .vec_len   (vec_len),
    .src_data  (src_data),
    .aux_data  (aux_data),
    .busy      (busy),
    .done      (done),
    .out_len   (out_len),
    .idx_err   (idx_err),
    .rd_src_sel(rd_src_sel),
    .rd_aux_sel(rd_aux_sel),
    .rd_elem   (rd_elem),
    .clr_en    (clr_en),
    .clr_sel   (clr_sel),
    .wa_en     (wa_en),
    .wa_sel    (wa_sel),
    .wa_elem   (wa_elem),
    .wa_data   (wa_data),
    .wb_en     (wb_en),
    .wb_sel    (wb_sel),
    .wb_elem   (wb_elem),
    .wb_data   (wb_data),
    .ev_accept (ev_accept),
    .ev_keep   (ev_keep),
    .ev_discard(ev_discard),
    .ev_last   (ev_last)
  );

  sgs_vrf #(
    .NREG(NREG), .MAXLEN(MAXLEN), .DW(DW), .SW(SW), .IW(IW)
  ) u_vrf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (clr_en),
    .clr_sel(clr_sel),
    .wa_en  (wa_en),
    .wa_sel (wa_sel),
    .wa_elem(wa_elem),
    .wa_data(wa_data),
    .wb_en  (wb_en),
    .wb_sel (wb_sel),
    .wb_elem(wb_elem),
    .wb_data(wb_data),
    .hw_en  (host_wr_fire),
    .hw_sel (host_sel),
    .hw_elem(host_elem),
    .hw_data(host_wdata),
    .ra_sel (rd_src_sel),
    .ra_elem(rd_elem),
    .ra_data(src_data),
    .rb_sel (rd_aux_sel),
    .rb_elem(rd_elem),
    .rb_data(aux_data),
    .rh_sel (host_sel),
    .rh_elem(host_elem),
    .rh_data(host_rdata)
  );

endmodule

// File: rtl/sgs_chk.sv
module sgs_chk #(
  parameter int MAXLEN = 64,
  parameter int LW     = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    op,
  input logic          busy,
  input logic          done,
  input logic [LW-1:0] out_len,
  input logic          idx_err,
  input logic          host_wr_fire,
  input logic          ev_accept,
  input logic          ev_keep,
  input logic          ev_discard,
  input logic          ev_last
);

  AST_DONE_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R6

  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> done);  // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> idx_err);  // R4

  AST_DISCARD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_discard |=> idx_err);  // R4

  AST_OUT_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_len <= LW'(MAXLEN));  // R1

  AST_KEEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_keep |-> busy);  // R1

  AST_HOST_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_fire |-> !busy);  // R9

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_accept);  // R7

  AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op == 2'd3) |=> (!busy && !done));  // R7

endmodule

bind sgs_unit sgs_chk #(.MAXLEN(MAXLEN), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .op          (op),
  .busy        (busy),
  .done        (done),
  .out_len     (out_len),
  .idx_err     (idx_err),
  .host_wr_fire(host_wr_fire),
  .ev_accept   (ev_accept),
  .ev_keep     (ev_keep),
  .ev_discard  (ev_discard),
  .ev_last     (ev_last)
);

// File: tb/sim_sgs_unit.sv
`timescale 1ns/1ps
module sim_sgs_unit;

  localparam int NREG = 4, MAXLEN = 8, DW = 8, SW = 2, IW = 3, LW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, start, busy, done, idx_err, host_we;
  logic [1:0]    op;
  logic [SW-1:0] src_sel, aux_sel, dst_sel, host_sel;
  logic [LW-1:0] vec_len, out_len;
  logic [IW-1:0] host_elem;
  logic [DW-1:0] host_wdata, host_rdata;

  sgs_unit #(.NREG(NREG), .MAXLEN(MAXLEN), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_sel(src_sel), .aux_sel(aux_sel), .dst_sel(dst_sel), .vec_len(vec_len),
    .busy(busy), .done(done), .out_len(out_len), .idx_err(idx_err),
    .host_we(host_we), .host_sel(host_sel), .host_elem(host_elem),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int checks = 0;
  int errors = 0;
  int model [NREG][MAXLEN];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int s, int e, int d);
    @(negedge clk);
    host_we = 1'b1; host_sel = SW'(s); host_elem = IW'(e); host_wdata = DW'(d);
    @(posedge clk);
    #1 host_we = 1'b0;
    model[s][e] = d & 8'hFF;
  endtask

  task automatic cmp_reg(string req, int s);
    for (int e = 0; e < MAXLEN; e++) begin
      @(negedge clk);
      host_sel = SW'(s); host_elem = IW'(e);
      #1 check(req, $sformatf("reg%0d[%0d]", s, e), int'(host_rdata), model[s][e]);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; op = '0; host_we = 1'b0;
    src_sel = '0; aux_sel = '0; dst_sel = '0; vec_len = '0;
    host_sel = '0; host_elem = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < MAXLEN; e++) model[r][e] = 0;
  endtask

  task automatic check_reset_state();
    @(negedge clk);
    check("R10", "busy", int'(busy), 0);
    check("R10", "done", int'(done), 0);
    check("R10", "idx_err", int'(idx_err), 0);
    check("R10", "out_len", int'(out_len), 0);
    for (int r = 0; r < NREG; r++) cmp_reg("R10", r);
  endtask

  // Starts an operation, optionally disturbing it while busy, and checks timing (R6).
  task automatic run_op(int o, int s, int a, int d, int len, int exp_lat, bit poke);
    int lat;
    @(negedge clk);
    start = 1'b1; op = 2'(o); src_sel = SW'(s); aux_sel = SW'(a); dst_sel = SW'(d);
    vec_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 64) begin
      if (poke && lat == 2) begin
        start = 1'b1; op = 2'd2;
        host_we = 1'b1; host_sel = 2'd3; host_elem = '0; host_wdata = 8'h99;
      end
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
      lat++;
    end
    check("R6", "done latency", lat, exp_lat);
    check("R6", "busy with done", int'(busy), 0);
    @(negedge clk);
    check("R6", "done single pulse", int'(done), 0);
  endtask

  int gcount;
  task automatic model_gather(int s, int a, int d, int len);
    int l;
    l = (len > MAXLEN) ? MAXLEN : len;
    gcount = 0;
    for (int e = 0; e < l; e++)
      if (model[s][e] != 0) begin
        model[d][gcount] = model[s][e];
        model[a][gcount] = e;
        gcount++;
      end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check_reset_state();

    // R1 R2: gather over every zero/non-zero pattern, full length.
    for (int pat = 0; pat < 256; pat++) begin
      for (int e = 0; e < MAXLEN; e++)
        wr(0, e, pat[e] ? ((e * 37 + pat) % 255) + 1 : 0);
      for (int e = 0; e < MAXLEN; e++) begin
        wr(1, e, 8'hA5 ^ pat);
        wr(2, e, 8'h5A ^ e);
      end
      model_gather(0, 2, 1, MAXLEN);
      run_op(0, 0, 2, 1, MAXLEN, MAXLEN + 1, 1'b0);
      check("R1", "kept count", int'(out_len), gcount);
      cmp_reg("R1", 1);
      cmp_reg("R2", 2);
    end

    // R1 R6: length sweep, including zero.
    for (int len = 0; len <= MAXLEN; len++) begin
      for (int e = 0; e < MAXLEN; e++) wr(0, e, (e % 3 == 1) ? 0 : e + 10);
      for (int e = 0; e < MAXLEN; e++) begin wr(1, e, 8'hC3); wr(2, e, 8'h3C); end
      model_gather(0, 2, 1, len);
      run_op(0, 0, 2, 1, len, len + 1, 1'b0);
      check("R1", "kept count by length", int'(out_len), gcount);
      cmp_reg("R1", 1);
      cmp_reg("R2", 2);
    end

    // R8: over-long length clamps to the depth.
    model_gather(0, 2, 1, 12);
    run_op(0, 0, 2, 1, 12, MAXLEN + 1, 1'b0);
    check("R8", "clamped kept count", int'(out_len), gcount);
    cmp_reg("R8", 1);

    // R3: scatter with repeats and every length.
    for (int s = 0; s < 40; s++) begin
      int l;
      l = (s == 39) ? MAXLEN : s % (MAXLEN + 1);
      for (int k = 0; k < MAXLEN; k++) begin
        wr(0, k, (k * 29 + s * 7) % 256);
        wr(1, k, (l > 0) ? (k * (s % 4) + s) % l : 0);
        wr(2, k, 8'h77 ^ s);
      end
      for (int e = 0; e < MAXLEN; e++) model[2][e] = 0;
      for (int k = 0; k < l; k++) model[2][model[1][k]] = model[0][k];
      run_op(1, 0, 1, 2, l, l + 2, 1'b0);
      cmp_reg("R3", 2);
      check("R4", "no error for in-range indices", int'(idx_err), 0);
    end

    // R4: out-of-range indices are dropped and flag sticks.
    for (int k = 0; k < MAXLEN; k++) begin
      wr(0, k, k + 1);
      wr(2, k, 8'hEE);
    end
    wr(1, 0, 0); wr(1, 1, 7); wr(1, 2, 2); wr(1, 3, 5); wr(1, 4, 200);
    wr(1, 5, 1); wr(1, 6, 1); wr(1, 7, 1);
    for (int e = 0; e < MAXLEN; e++) model[2][e] = 0;
    model[2][0] = 1; model[2][2] = 3;
    run_op(1, 0, 1, 2, 5, 7, 1'b0);
    cmp_reg("R4", 2);
    check("R4", "flag set", int'(idx_err), 1);
    wr(1, 1, 3); wr(1, 3, 4); wr(1, 4, 1);
    for (int e = 0; e < MAXLEN; e++) model[2][e] = 0;
    model[2][0] = 1; model[2][3] = 2; model[2][2] = 3; model[2][4] = 4; model[2][1] = 5;
    run_op(1, 0, 1, 2, 5, 7, 1'b0);
    cmp_reg("R3", 2);
    check("R4", "flag stays set", int'(idx_err), 1);

    // R10: reset again clears everything.
    do_reset();
    check_reset_state();

    // R5: mask over every control pattern with varying length.
    for (int m = 0; m < 256; m++) begin
      int l;
      l = (m < 128) ? MAXLEN : m % (MAXLEN + 1);
      for (int e = 0; e < MAXLEN; e++) begin
        wr(0, e, (e * 11 + m) % 256);
        wr(1, e, m[e] ? ((m + e) % 255) + 1 : 0);
        wr(2, e, 8'h3C);
      end
      for (int e = 0; e < l; e++) if (model[1][e] != 0) model[2][e] = model[0][e];
      run_op(2, 0, 1, 2, l, l + 1, 1'b0);
      cmp_reg("R5", 2);
    end

    // R7 R9: start and host write during busy are ignored.
    for (int e = 0; e < MAXLEN; e++) begin
      wr(0, e, (e == 2 || e == 5) ? 0 : e + 40);
      wr(1, e, 8'h11);
      wr(2, e, 8'h22);
    end
    wr(3, 0, 8'h44);
    model_gather(0, 2, 1, MAXLEN);
    run_op(0, 0, 2, 1, MAXLEN, MAXLEN + 1, 1'b1);
    check("R7", "kept count after ignored start", int'(out_len), gcount);
    cmp_reg("R7", 1);
    cmp_reg("R7", 2);
    cmp_reg("R9", 3);

    // R7: reserved opcode does nothing.
    @(negedge clk);
    start = 1'b1; op = 2'd3; src_sel = 2'd0; aux_sel = 2'd1; dst_sel = 2'd3; vec_len = 4'd8;
    @(negedge clk);
    start = 1'b0;
    check("R7", "reserved busy", int'(busy), 0);
    check("R7", "reserved done", int'(done), 0);
    repeat (10) @(negedge clk);
    cmp_reg("R7", 3);

    // R9: combinational read of a just-written element.
    wr(3, 6, 8'hB7);
    @(negedge clk);
    host_sel = 2'd3; host_elem = 3'd6;
    #1 check("R9", "host readback", int'(host_rdata), 8'hB7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule